// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits on a 32-bit transmit word path, between the buffer the host writes packets into and the MAC. Each packet starts with two command words. When checksum offload is requested, a descriptor word follows the two command words, and the Ethernet frame comes after it. The block stores the whole packet before it sends any of it. While the frame arrives, the block adds up its bytes from a chosen start offset to the last byte. When the frame is complete, the block writes the ones' complement of the folded sum over two bytes at a chosen insert offset. It then sends the command words and the frame downstream, with byte enables and a last-word marker.

Offload is requested only when three flags are all set: the global enable input, the first-segment flag in the first command word, and the checksum flag in the second command word. Without that request there is no descriptor word, and the packet leaves the block exactly as it arrived. With the request, the descriptor word is removed from the stream. If either offset falls inside the protected region, the frame is sent without any change and a sticky error flag is raised.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `csum_err` are 0.
- R2: If `cfg_enable`, bit 13 of the first command word or bit 14 of the second command word is clear, no descriptor word follows the commands. The output is then every input word unchanged, in the same order.
- R3: When all three flags are set, the third input word is the descriptor. That word is not sent. The output is the two command words followed by the frame words.
- R4: Frame byte 0 is in bits 31:24 of the first frame word. Descriptor bits 11:0 give the start offset and bits 27:16 give the insert offset. The sum covers every byte from the start offset to the last byte of the frame. A byte at an even offset counts as the high half of a 16-bit word, and a byte at an odd offset counts as the low half. Carries out of bit 15 are added back in. The complement of the result is written high byte at the insert offset and low byte at the insert offset plus 1.
- R5: The two inserted bytes are placed correctly even when they fall in two different words.
- R6: Bytes at the insert position that lie inside the summed range are counted with their original values. The final value then replaces them.
- R7: The offsets are legal only if start ≥ 14, start + 4 < length, insert ≥ 14 and insert + 6 ≤ length. If they are not, the frame goes out unmodified and `csum_err` rises and stays 1 until reset.
- R8: `out_valid` goes high only after the last input word has been taken. `in_ready` and `out_valid` are never both 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output word, byte enables and last marker hold steady. `out_keep` is 4'b1111 on every word except the last. On the last word it equals the input's last `in_keep`: 1000, 1100, 1110 or 1111, where bit 3 marks bits 31:24.
- R10: Descriptor bits 31:28 and 15:12 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global offload enable |
| in_data | input | 32 | Input word: commands, descriptor, frame |
| in_keep | input | 4 | Valid byte lanes on the last input word |
| in_last | input | 1 | Marks the last input word of a packet |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| out_data | output | 32 | Output word |
| out_keep | output | 4 | Valid byte lanes of the output word |
| out_last | output | 1 | Marks the last output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| csum_err | output | 1 | Sticky flag for illegal offsets |

## Verification
Two functions can act on the same byte. The sum reads a byte while the insertion overwrites it. Directed packets put the insert offset inside the summed range and across a word boundary. Random packets draw start and insert offsets independently, so the two often overlap. The bench model always sums the original bytes and only then patches its copy. Any output word that reflects patched bytes in the sum, or patching in the wrong lane, is reported.

// File: rtl/tx_csum_pkg.sv
package tx_csum_pkg;

  typedef enum logic [2:0] {
    ST_CMDA,
    ST_CMDB,
    ST_DESC,
    ST_DATA,
    ST_CALC,
    ST_EMIT
  } txcs_state_e;

  localparam int FIRST_SEG_BIT = 13;
  localparam int CSUM_REQ_BIT  = 14;
  localparam int HDR_LEN       = 14;
  localparam int TAIL_LEN      = 4;
  localparam int OFF_W         = 12;
  localparam int START_LSB     = 0;
  localparam int INS_LSB       = 16;

  // fold carries twice and complement
  function automatic logic [15:0] fold_cpl(input logic [31:0] s);
    logic [16:0] a;
    logic [15:0] b;
    a = {1'b0, s[31:16]} + {1'b0, s[15:0]};
    b = a[15:0] + {15'd0, a[16]};
    return ~b;
  endfunction

endpackage

// File: rtl/txcs_sum_acc.sv
module txcs_sum_acc #(
  parameter int BW    = 13,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [8*LANES-1:0] word,
  input  logic [LANES-1:0]   keep,
  input  logic [BW-1:0]      base,
  input  logic [BW-1:0]      start,
  output logic [31:0]        acc
);

  logic [31:0] part [LANES];
  logic [31:0] word_sum;
  logic [31:0] acc_d;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int SH = ((g % 2) == 0) ? 8 : 0;
      logic [BW-1:0] pos;
      logic [7:0]    byte_v;
      assign pos    = base + BW'(g);
      assign byte_v = word[8*(LANES-1-g) +: 8];
      assign part[g] = (keep[LANES-1-g] && (pos >= start)) ? (32'(byte_v) << SH) : 32'd0;
    end
  endgenerate

  always_comb begin
    word_sum = 32'd0;
    for (int i = 0; i < LANES; i++) word_sum = word_sum + part[i];
  end

  always_comb begin
    acc_d = acc;
    if (clr)     acc_d = 32'd0;
    else if (en) acc_d = acc + word_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= 32'd0;
    else        acc <= acc_d;
  end

endmodule

// File: rtl/txcs_word_buf.sv
module txcs_word_buf #(
  parameter int DEPTH = 512,
  parameter int WW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txcs_patch.sv
module txcs_patch #(
  parameter int BW    = 13,
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] win,
  input  logic [BW-1:0]      base,
  input  logic [BW-1:0]      ins,
  input  logic [15:0]        value,
  input  logic               en,
  output logic [8*LANES-1:0] wout
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BW-1:0] pos;
      logic          hit_hi;
      logic          hit_lo;
      assign pos    = base + BW'(g);
      assign hit_hi = en && (pos == ins);
      assign hit_lo = en && (pos == ins + BW'(1));
      assign wout[8*(LANES-1-g) +: 8] = hit_hi ? value[15:8] :
                                        hit_lo ? value[7:0]  :
                                                 win[8*(LANES-1-g) +: 8];
    end
  endgenerate

endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert #(
  parameter int DEPTH_W = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_enable,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_keep,
  input  logic        in_last,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_keep,
  output logic        out_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        csum_err
);
  import tx_csum_pkg::*;

  localparam int AW    = $clog2(DEPTH_W);
  localparam int BW    = ((AW + 3) > 13) ? (AW + 3) : 13;
  localparam int LANES = 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  txcs_state_e state_q, state_d;
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d, lptr_q, lptr_d;
  logic [3:0]       lkeep_q, lkeep_d;
  logic [BW-1:0]    dbase_q, dbase_d, obase_q, obase_d, flen_q, flen_d;
  logic [OFF_W-1:0] start_q, start_d, ins_q, ins_d;
  logic             fs_q, fs_d, req_q, req_d, doins_q, doins_d, err_q, err_d;
  logic [15:0]      cs_q, cs_d;

  logic        in_fire, out_fire, we, sum_clr, sum_en, offs_ok, at_last;
  logic [31:0] acc, rdata;
  logic [3:0]  sum_keep;
  logic [BW-1:0] start_x, ins_x;

  assign in_ready = (state_q == ST_CMDA) || (state_q == ST_CMDB) ||
                    (state_q == ST_DESC) || (state_q == ST_DATA);
  assign in_fire  = in_valid && in_ready;
  assign out_valid = (state_q == ST_EMIT);
  assign out_fire  = out_valid && out_ready;
  assign at_last   = (rptr_q == lptr_q);

  assign we       = in_fire && (state_q != ST_DESC);
  assign sum_clr  = in_fire && (state_q == ST_CMDA);
  assign sum_en   = in_fire && (state_q == ST_DATA) && req_q;
  assign sum_keep = in_last ? in_keep : 4'hF;
  assign start_x  = BW'(start_q);
  assign ins_x    = BW'(ins_q);

  assign offs_ok = (start_x >= BW'(HDR_LEN)) && ((start_x + BW'(TAIL_LEN)) < flen_q) &&
                   (ins_x >= BW'(HDR_LEN)) && ((ins_x + BW'(TAIL_LEN + 2)) <= flen_q);

  txcs_word_buf #(.DEPTH(DEPTH_W), .WW(32), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (we),
    .waddr (wptr_q),
    .wdata (in_data),
    .raddr (rptr_q),
    .rdata (rdata)
  );

  txcs_sum_acc #(.BW(BW), .LANES(LANES)) u_sum (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (sum_clr),
    .en    (sum_en),
    .word  (in_data),
    .keep  (sum_keep),
    .base  (dbase_q),
    .start (start_x),
    .acc   (acc)
  );

  txcs_patch #(.BW(BW), .LANES(LANES)) u_patch (
    .win   (rdata),
    .base  (obase_q),
    .ins   (ins_x),
    .value (cs_q),
    .en    (doins_q && (rptr_q >= AW'(2))),
    .wout  (out_data)
  );

  assign out_keep = at_last ? lkeep_q : 4'hF;
  assign out_last = out_valid && at_last;
  assign csum_err = err_q;

  always_comb begin
    state_d = state_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    lptr_d  = lptr_q;
    lkeep_d = lkeep_q;
    dbase_d = dbase_q;
    obase_d = obase_q;
    flen_d  = flen_q;
    start_d = start_q;
    ins_d   = ins_q;
    fs_d    = fs_q;
    req_d   = req_q;
    doins_d = doins_q;
    err_d   = err_q;
    cs_d    = cs_q;
    case (state_q)
      ST_CMDA: if (in_fire) begin
        fs_d    = in_data[FIRST_SEG_BIT];
        wptr_d  = wptr_q + AW'(1);
        dbase_d = '0;
        state_d = ST_CMDB;
      end
      ST_CMDB: if (in_fire) begin
        req_d   = cfg_enable && fs_q && in_data[CSUM_REQ_BIT];
        wptr_d  = wptr_q + AW'(1);
        state_d = req_d ? ST_DESC : ST_DATA;
      end
      ST_DESC: if (in_fire) begin
        start_d = in_data[START_LSB +: OFF_W];
        ins_d   = in_data[INS_LSB +: OFF_W];
        state_d = ST_DATA;
      end
      ST_DATA: if (in_fire) begin
        wptr_d  = wptr_q + AW'(1);
        dbase_d = dbase_q + BW'(LANES);
        if (in_last) begin
          lptr_d  = wptr_q;
          lkeep_d = in_keep;
          flen_d  = dbase_q + BW'($countones(in_keep));
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        doins_d = req_q && offs_ok;
        if (req_q && !offs_ok) err_d = 1'b1;
        cs_d    = fold_cpl(acc);
        rptr_d  = '0;
        obase_d = '0;
        state_d = ST_EMIT;
      end
      ST_EMIT: if (out_fire) begin
        if (at_last) begin
          wptr_d  = '0;
          state_d = ST_CMDA;
        end else begin
          rptr_d = rptr_q + AW'(1);
          if (rptr_q >= AW'(2)) obase_d = obase_q + BW'(LANES);
        end
      end
      default: state_d = ST_CMDA;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_CMDA;
      wptr_q  <= '0;
      rptr_q  <= '0;
      lptr_q  <= '0;
      lkeep_q <= 4'hF;
      dbase_q <= '0;
      obase_q <= '0;
      flen_q  <= '0;
      start_q <= '0;
      ins_q   <= '0;
      fs_q    <= 1'b0;
      req_q   <= 1'b0;
      doins_q <= 1'b0;
      err_q   <= 1'b0;
      cs_q    <= 16'd0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      lptr_q  <= lptr_d;
      lkeep_q <= lkeep_d;
      dbase_q <= dbase_d;
      obase_q <= obase_d;
      flen_q  <= flen_d;
      start_q <= start_d;
      ins_q   <= ins_d;
      fs_q    <= fs_d;
      req_q   <= req_d;
      doins_q <= doins_d;
      err_q   <= err_d;
      cs_q    <= cs_d;
    end
  end

endmodule

// File: rtl/tx_csum_insert_chk.sv
module tx_csum_insert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_keep,
  input logic        out_last,
  input logic        csum_err
);

  // R8
  sf_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_keep) && $stable(out_last)));

  // R9
  keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep inside {4'b1000, 4'b1100, 4'b1110, 4'b1111}));

  // R9
  keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_keep == 4'hF));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |=> csum_err);

endmodule

bind tx_csum_insert tx_csum_insert_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_keep  (out_keep),
  .out_last  (out_last),
  .csum_err  (csum_err)
);

// File: tb/tx_csum_insert_test.sv
module tx_csum_insert_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_enable;
  logic [31:0] in_data;
  logic [3:0]  in_keep;
  logic        in_last;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last;
  logic        out_valid;
  logic        out_ready;
  logic        csum_err;

  tx_csum_insert uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .in_data    (in_data),
    .in_keep    (in_keep),
    .in_last    (in_last),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_data   (out_data),
    .out_keep   (out_keep),
    .out_last   (out_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .csum_err   (csum_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          n_chk;
  int          n_bad;
  bit          finished;
  logic [7:0]  fr  [0:2047];
  logic [7:0]  ex  [0:2047];
  logic [31:0] inw [0:600];
  logic [31:0] exw [0:600];
  int          n_in;
  int          n_out;
  logic [3:0]  lk;
  bit          err_exp;
  bit          drv_done;
  bit          sf_bad;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_desc(input int st, input int ins, input logic [3:0] r_hi, input logic [3:0] r_lo);
    logic [11:0] s12;
    logic [11:0] i12;
    s12 = st[11:0];
    i12 = ins[11:0];
    return {r_hi, i12, r_lo, s12};
  endfunction

  task automatic fill(input int len);
    for (int p = 0; p < len; p++) fr[p] = 8'($urandom);
    for (int p = len; p < len + 4; p++) fr[p] = 8'h00;
  endtask

  task automatic drive();
    for (int i = 0; i < n_in; i++) begin
      @(negedge clk);
      if (($urandom % 5) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = inw[i];
      in_last  = (i == n_in - 1);
      in_keep  = (i == n_in - 1) ? lk : 4'hF;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    drv_done = 1'b1;
  endtask

  task automatic collect(input string tag);
    int got;
    got = 0;
    while (got < n_out) begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      #2;
      if (out_valid && !drv_done) sf_bad = 1'b1;
      if (out_valid && out_ready) begin
        check(tag, out_data, exw[got]);
        // R9 byte enables and last marker
        check("R9 keep", {28'd0, out_keep}, (got == n_out - 1) ? {28'd0, lk} : 32'hF);
        check("R9 last", {31'd0, out_last}, {31'd0, (got == n_out - 1)});
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_pkt(input bit en, input bit fs, input bit ck, input logic [31:0] desc,
                         input int len, input string tag);
    logic [31:0] a, b, s;
    logic [15:0] cs;
    bit req, ok;
    int st, io, nw;
    a = $urandom; a[13] = fs;
    b = $urandom; b[14] = ck;
    req = en && fs && ck;
    for (int p = 0; p < len + 4; p++) ex[p] = fr[p];
    if (req) begin
      st = int'(desc[11:0]);
      io = int'(desc[27:16]);
      ok = (st >= 14) && (st + 4 < len) && (io >= 14) && (io + 6 <= len);
      if (ok) begin
        s = 32'd0;
        for (int p = st; p < len; p++)
          s = s + (((p % 2) == 0) ? {16'd0, fr[p], 8'd0} : {24'd0, fr[p]});
        while (s[31:16] != 16'd0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        cs = ~s[15:0];
        ex[io]     = cs[15:8];
        ex[io + 1] = cs[7:0];
      end else begin
        err_exp = 1'b1;
      end
    end
    nw = (len + 3) / 4;
    case (len % 4)
      0: lk = 4'b1111;
      1: lk = 4'b1000;
      2: lk = 4'b1100;
      default: lk = 4'b1110;
    endcase
    n_in = 0;
    inw[n_in++] = a;
    inw[n_in++] = b;
    if (req) inw[n_in++] = desc;
    exw[0] = a;
    exw[1] = b;
    for (int w = 0; w < nw; w++) begin
      inw[n_in++] = {fr[4*w], fr[4*w+1], fr[4*w+2], fr[4*w+3]};
      exw[2 + w]  = {ex[4*w], ex[4*w+1], ex[4*w+2], ex[4*w+3]};
    end
    n_out = 2 + nw;
    cfg_enable = en;
    drv_done = 1'b0;
    sf_bad = 1'b0;
    fork
      drive();
      collect(tag);
    join
    // R8 nothing emitted before the whole packet was taken
    check("R8 store-forward", {31'd0, sf_bad}, 32'd0);
    // R7 error flag
    check("R7 err", {31'd0, csum_err}, {31'd0, err_exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len, st, io;
    bit en, fs, ck;
    n_chk = 0; n_bad = 0; finished = 1'b0; err_exp = 1'b0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_enable = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    in_data = 32'd0; in_keep = 4'hF; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 csum_err", {31'd0, csum_err}, 32'd0);

    // R2 each gating flag clear
    fill(40); run_pkt(1'b0, 1'b1, 1'b1, mk_desc(14, 16, 4'h0, 4'h0), 40, "R2 enable off");
    fill(41); run_pkt(1'b1, 1'b0, 1'b1, mk_desc(14, 16, 4'h0, 4'h0), 41, "R2 first-seg off");
    fill(42); run_pkt(1'b1, 1'b1, 1'b0, mk_desc(14, 16, 4'h0, 4'h0), 42, "R2 csum flag off");
    // R3 R4 basic insert
    fill(60); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(14, 16, 4'h0, 4'h0), 60, "R3 R4 basic");
    // R5 straddling insert, odd length
    fill(61); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(15, 19, 4'h0, 4'h0), 61, "R5 straddle");
    // R4 boundary offsets
    fill(62); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(57, 56, 4'h0, 4'h0), 62, "R4 edge offsets");
    // R6 insert inside summed range
    fill(80); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(20, 30, 4'h0, 4'h0), 80, "R6 partial");
    // R10 reserved bits set
    fill(80); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(22, 40, 4'hF, 4'hF), 80, "R10 reserved");
    // R9 every last-word shape
    for (int l = 64; l < 68; l++) begin
      fill(l); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(17, 33, 4'h0, 4'h0), l, "R9 R4 tail");
    end
    // random legal packets
    for (int k = 0; k < 40; k++) begin
      len = 20 + int'($urandom % 180);
      en  = (($urandom % 4) != 0);
      fs  = (($urandom % 4) != 0);
      ck  = (($urandom % 4) != 0);
      st  = 14 + int'($urandom % (len - 18));
      io  = 14 + int'($urandom % (len - 19));
      fill(len);
      run_pkt(en, fs, ck, mk_desc(st, io, 4'($urandom), 4'($urandom)), len, "R4 R6 random");
    end
    // R7 illegal offsets
    fill(50); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(13, 20, 4'h0, 4'h0), 50, "R7 start in header");
    fill(50); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(14, 45, 4'h0, 4'h0), 50, "R7 insert in tail");
    fill(50); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(46, 20, 4'h0, 4'h0), 50, "R7 start in tail");
    fill(50); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(20, 13, 4'h0, 4'h0), 50, "R7 insert in header");
    fill(70); run_pkt(1'b1, 1'b1, 1'b1, mk_desc(14, 18, 4'h0, 4'h0), 70, "R7 sticky then legal");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule